// File: doc/BRIEF.md
# Cross-Domain Mailbox Flag Register

This block holds a small bank of mailboxes that a host expansion bus writes and an internal core reads. Each mailbox has a data word and a ready flag. The host writes a word to a mailbox address. The flag for that mailbox then rises in the core clock domain, and the core drops it again with a per-mailbox clear strobe once it has taken the word. One mailbox is marked as the attention mailbox, and its flag is also driven on a separate output that the core can use as an interrupt.

A host write is recognised when three things hold together: the bus-operation qualifier is high, the active-low write strobe is low, and the address matches the mailbox. This term is computed and captured in a register clocked by the host bus clock. The core side receives only that register's output, with no gating in between. It passes the bit through a three-stage synchronizer and then a rising-edge detector. The flag is set only by that edge. Because the term is registered first, a short glitch from the address compare cannot arrive in the core as a set request for the wrong mailbox. The data word is captured in the host domain on the same write, so it is stable well before the synchronized edge sets the flag.

Top module: `mbx_flag_xdc`

## Requirements
- R1: While reset is asserted, and after reset is released with no write since, every flag, `core_attn` and every mailbox word read 0.
- R2: A host write (`bus_op`=1, `bus_wr_n`=0) to address BASE_ADDR+i (default addresses 0 to 3 for mailboxes 0 to 3) sets flag i on `core_flag[i]` within a few core clock cycles.
- R3: An access with `bus_op`=0, an access with `bus_wr_n`=1, or a write to any address outside the mailbox range (default 4 to 15) changes no flag and no mailbox word.
- R4: A write to mailbox i stores `bus_wdata` in `core_mb_data[i*DATA_W +: DATA_W]`, and that word holds its new value by the time flag i reads 1.
- R5: A flag is set only on the rising edge of the synchronized request. If a write to one address is held across many bus cycles, it sets the flag once, and a clear given during the hold keeps the flag at 0 until the write ends and a new write begins.
- R6: A pulse on `core_clr[i]` clears flag i on the next core clock edge and leaves every other flag unchanged.
- R7: If a set edge and a clear for the same mailbox fall in the same core cycle, the flag reads 1 after that edge. With the clear held high throughout, one write makes the flag read 1 for exactly one core cycle.
- R8: `core_attn` follows the flag of mailbox ATTN_IDX (default 3).
- R9: Back-to-back writes to neighbouring addresses in consecutive bus cycles set exactly the flags of the addresses written, and each of those mailboxes keeps the last word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst_n | input | 1 | Host-domain reset, active low, asynchronous assert |
| bus_op | input | 1 | Bus-operation qualifier, high during a valid cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain reset, active low, asynchronous assert |
| core_clr | input | NUM_MB | Per-mailbox flag clear strobe |
| core_flag | output | NUM_MB | Per-mailbox ready flag |
| core_attn | output | 1 | Flag of the attention mailbox |
| core_mb_data | output | NUM_MB*DATA_W | Mailbox words, mailbox i in slice i |

## Verification
The assertions rely on two things. Each core reset is released in step with its own clock. The host bus clock is slower than the core clock, so a one-bus-cycle request stays high across at least two core edges and the synchronizer sees every pulse. The stimulus uses a 15 ns bus clock against the 5 ns core clock, and it changes bus inputs only on the bus clock's falling edge. The stimulus does not pulse a clear while a write to the same mailbox is still settling, except in the directed case that holds the clear high on purpose to test that set wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MB_COUNT   = 4;
  localparam int MB_ADDR_W  = 4;
  localparam int MB_DATA_W  = 16;
  localparam int MB_SYNC_N  = 3;
  localparam int MB_ATTN    = 3;

  // Address of mailbox idx relative to a base
  function automatic logic [MB_ADDR_W-1:0] mb_addr(input int base, input int idx);
    return MB_ADDR_W'(base + idx);
  endfunction
endpackage

// File: rtl/mbx_bus_capture.sv
module mbx_bus_capture #(
  parameter int NUM_MB    = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int BASE_ADDR = 0
) (
  input  logic                           bus_clk,
  input  logic                           bus_rst_n,
  input  logic                           bus_op,
  input  logic                           bus_wr_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [NUM_MB-1:0]              req_q,
  output logic [NUM_MB-1:0][DATA_W-1:0]  word_q
);
  logic                          wr_qual;
  logic [NUM_MB-1:0]             hit_d;
  logic [NUM_MB-1:0][DATA_W-1:0] word_d;

  assign wr_qual = bus_op & ~bus_wr_n;

  // Full decode term per mailbox; only ever leaves this domain through req_q
  for (genvar g = 0; g < NUM_MB; g++) begin : g_dec
    always_comb begin
      hit_d[g]  = wr_qual & (bus_addr == ADDR_W'(BASE_ADDR + g));
      word_d[g] = word_q[g];
      if (hit_d[g]) word_d[g] = bus_wdata;
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_q  <= '0;
      word_q <= '0;
    end else begin
      req_q  <= hit_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/mbx_sync_edge.sv
module mbx_sync_edge #(
  parameter int STAGES = 3
) (
  input  logic core_clk,
  input  logic core_rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;
  logic         last_q;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[TOP-1:0], async_in};
    end else begin : g_single
      assign chain_d = async_in;
    end
  endgenerate

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[TOP];
    end
  end

  assign rise = chain_q[TOP] & ~last_q;
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int NUM_MB = 4
) (
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic [NUM_MB-1:0] set_pulse,
  input  logic [NUM_MB-1:0] clr,
  output logic [NUM_MB-1:0] flag_q
);
  logic [NUM_MB-1:0] flag_d;
  logic [NUM_MB-1:0] flag_en;

  // Set has priority over clear
  for (genvar g = 0; g < NUM_MB; g++) begin : g_flag
    always_comb begin
      flag_en[g] = set_pulse[g] | clr[g];
      flag_d[g]  = set_pulse[g];
    end
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (flag_en[i]) flag_q[i] <= flag_d[i];
      end
    end
  end
endmodule

// File: rtl/mbx_flag_xdc.sv
module mbx_flag_xdc #(
  parameter int NUM_MB    = mbx_pkg::MB_COUNT,
  parameter int ADDR_W    = mbx_pkg::MB_ADDR_W,
  parameter int DATA_W    = mbx_pkg::MB_DATA_W,
  parameter int BASE_ADDR = 0,
  parameter int SYNC_N    = mbx_pkg::MB_SYNC_N,
  parameter int ATTN_IDX  = mbx_pkg::MB_ATTN
) (
  input  logic                     bus_clk,
  input  logic                     bus_rst_n,
  input  logic                     bus_op,
  input  logic                     bus_wr_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     core_clk,
  input  logic                     core_rst_n,
  input  logic [NUM_MB-1:0]        core_clr,
  output logic [NUM_MB-1:0]        core_flag,
  output logic                     core_attn,
  output logic [NUM_MB*DATA_W-1:0] core_mb_data
);
  logic [NUM_MB-1:0]             req_q;
  logic [NUM_MB-1:0][DATA_W-1:0] word_q;
  logic [NUM_MB-1:0]             set_pulse;

  mbx_bus_capture #(
    .NUM_MB(NUM_MB), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) u_cap (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_op(bus_op),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .req_q(req_q), .word_q(word_q)
  );

  // Registered request goes straight into the synchronizer
  for (genvar g = 0; g < NUM_MB; g++) begin : g_xing
    mbx_sync_edge #(.STAGES(SYNC_N)) u_sync (
      .core_clk(core_clk), .core_rst_n(core_rst_n),
      .async_in(req_q[g]), .rise(set_pulse[g])
    );
  end

  mbx_flag_bank #(.NUM_MB(NUM_MB)) u_flags (
    .core_clk(core_clk), .core_rst_n(core_rst_n),
    .set_pulse(set_pulse), .clr(core_clr), .flag_q(core_flag)
  );

  assign core_attn    = core_flag[ATTN_IDX];
  assign core_mb_data = word_q;
endmodule

// File: rtl/mbx_flag_chk.sv
module mbx_flag_chk #(
  parameter int NUM_MB   = 4,
  parameter int ATTN_IDX = 3
) (
  input logic              core_clk,
  input logic              core_rst_n,
  input logic [NUM_MB-1:0] set_pulse,
  input logic [NUM_MB-1:0] core_clr,
  input logic [NUM_MB-1:0] core_flag,
  input logic              core_attn
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_prop
    AST_RISE_FROM_EDGE: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      $rose(core_flag[g]) |-> $past(set_pulse[g])); // R5
    AST_EDGE_SINGLE: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      set_pulse[g] |=> !set_pulse[g]); // R5
    AST_SET_LANDS: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      set_pulse[g] |=> core_flag[g]); // R7
    AST_CLR_DROPS: assert property (@(posedge core_clk) disable iff (!core_rst_n)
      (core_clr[g] && !set_pulse[g]) |=> !core_flag[g]); // R6
  end

  AST_ATTN_RISE: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    $rose(core_attn) |-> $past(set_pulse[ATTN_IDX])); // R8
endmodule

bind mbx_flag_xdc mbx_flag_chk #(.NUM_MB(NUM_MB), .ATTN_IDX(ATTN_IDX)) u_chk (
  .core_clk(core_clk), .core_rst_n(core_rst_n), .set_pulse(set_pulse),
  .core_clr(core_clr), .core_flag(core_flag), .core_attn(core_attn)
);

// File: tb/tb_mbx_flag_xdc.sv
module tb_mbx_flag_xdc;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic bus_clk = 0, core_clk = 0;
  logic bus_rst_n = 0, core_rst_n = 0;
  logic bus_op = 0, bus_wr_n = 1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [N-1:0] core_clr = '0;
  logic [N-1:0] core_flag;
  logic core_attn;
  logic [N*DW-1:0] core_mb_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] exp_flag = '0;
  logic [N-1:0][DW-1:0] exp_word = '0;

  always #2.5 core_clk = ~core_clk;
  always #7.5 bus_clk = ~bus_clk;

  mbx_flag_xdc dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_op(bus_op),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .core_clk(core_clk), .core_rst_n(core_rst_n), .core_clr(core_clr),
    .core_flag(core_flag), .core_attn(core_attn), .core_mb_data(core_mb_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected effect of one bus cycle
  function automatic bit is_hit(input logic op, input logic wr_n, input logic [AW-1:0] a);
    return op && !wr_n && (a < AW'(N));
  endfunction

  task automatic bus_cycle(input logic op, input logic wr_n, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
    @(negedge bus_clk);
    bus_op = op; bus_wr_n = wr_n; bus_addr = a; bus_wdata = d;
    if (is_hit(op, wr_n, a)) begin
      exp_flag[a] = 1'b1;
      exp_word[a] = d;
    end
  endtask

  task automatic bus_idle();
    @(negedge bus_clk);
    bus_op = 0; bus_wr_n = 1;
  endtask

  task automatic core_wait(input int n);
    repeat (n) @(negedge core_clk);
  endtask

  task automatic clear(input logic [N-1:0] m);
    @(negedge core_clk);
    core_clr = m;
    @(negedge core_clk);
    core_clr = '0;
    exp_flag = exp_flag & ~m;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " flags"}, 64'(core_flag), 64'(exp_flag));
    chk({tag, " words"}, core_mb_data, exp_word);
    chk({tag, " R8 attn"}, 64'(core_attn), 64'(exp_flag[3]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hold_cnt;
    void'($urandom(32'h5EED_1234));
    #20;
    chk("R1 flags in reset", 64'(core_flag), 64'h0);
    chk("R1 words in reset", core_mb_data, 64'h0);
    #30;
    @(negedge core_clk); core_rst_n = 1;
    @(negedge bus_clk);  bus_rst_n = 1;
    core_wait(4);
    chk("R1 flags after reset", 64'(core_flag), 64'h0);
    chk("R1 attn after reset", 64'(core_attn), 64'h0);
    chk("R1 words after reset", core_mb_data, 64'h0);

    // R3: non-writes and out-of-range writes
    bus_cycle(0, 0, 0, 16'h1111);
    bus_cycle(1, 1, 1, 16'h2222);
    for (int a = N; a < 16; a++) bus_cycle(1, 0, AW'(a), 16'(a * 16'h0101));
    bus_cycle(0, 1, 2, 16'h3333);
    bus_idle();
    core_wait(12);
    check_all("R3 ignored");

    // R2/R4: single write to each mailbox
    for (int m = 0; m < N; m++) begin
      bus_cycle(1, 0, AW'(m), 16'hA000 + 16'(m));
      bus_idle();
      core_wait(12);
      check_all("R2 R4 single");
    end
    clear(4'b0101);
    core_wait(2);
    check_all("R6 partial clear");
    clear(4'b1010);
    core_wait(2);
    check_all("R6 rest clear");

    // R9: neighbours back to back
    bus_cycle(1, 0, 1, 16'hB001);
    bus_cycle(1, 0, 2, 16'hB002);
    bus_cycle(1, 0, 4, 16'hB004);
    bus_cycle(1, 0, 1, 16'hB011);
    bus_idle();
    core_wait(12);
    check_all("R9 neighbours");
    clear('1);
    core_wait(2);

    // R5: held write, clear during hold
    bus_cycle(1, 0, 0, 16'hC0C0);
    core_wait(12);
    chk("R5 held sets", 64'(core_flag[0]), 64'h1);
    clear(4'b0001);
    core_wait(15);
    chk("R5 no reset while held", 64'(core_flag[0]), 64'h0);
    bus_idle();
    core_wait(12);
    chk("R5 release no set", 64'(core_flag[0]), 64'h0);
    bus_cycle(1, 0, 0, 16'hC0C1);
    bus_idle();
    core_wait(12);
    check_all("R5 new write");
    clear('1);
    core_wait(2);

    // R7: clear held high, flag visible exactly one cycle
    @(negedge core_clk); core_clr = 4'b0100;
    bus_cycle(1, 0, 2, 16'hD00D);
    bus_idle();
    hold_cnt = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge core_clk);
      if (core_flag[2]) hold_cnt++;
    end
    core_clr = '0;
    exp_flag[2] = 1'b0;
    chk("R7 set wins one cycle", 64'(hold_cnt), 64'd1);
    core_wait(2);
    check_all("R7 after");

    // Random bursts
    for (int r = 0; r < 40; r++) begin
      int len = $urandom_range(1, 6);
      for (int k = 0; k < len; k++) begin
        logic op   = ($urandom % 4) != 0;
        logic wr_n = ($urandom % 4) == 0;
        logic [AW-1:0] a = AW'($urandom_range(0, 7));
        bus_cycle(op, wr_n, a, 16'($urandom));
      end
      bus_idle();
      core_wait(12);
      check_all("R2 R3 R4 R9 random");
      clear(N'($urandom));
      core_wait(2);
      chk("R6 random clear", 64'(core_flag), 64'(exp_flag));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule